// File: doc/BRIEF.md
# Systolic Least-Squares Channel Estimator

This block forms the least-squares estimate of one user's antenna-domain channel vector from a training burst. The received training matrix has one row per antenna (ROWS) and one column per training symbol (SYMS). Each clock brings one complete column of ROWS complex samples. The block multiplies the matrix by the user's pilot sequence, scales each row sum by a real constant, and emits ROWS complex estimates in antenna order with a valid strobe.

Each column goes into the private row buffer of its own processing element. Each element holds one pilot symbol. It multiplies its buffered sample by that pilot, adds the partial sum from its left neighbour, and passes the result right. Because every element starts one cycle after its left neighbour, whole-column arrival turns into the staggered feed a linear systolic array needs. The pilot set and the scaling constant are loaded together before a burst. A load that arrives while a burst is in flight waits until the array is empty.

Top module: `ls_chan_est`

## Requirements
- R1: While rst_n is low, and until the first result row is due, out_valid is 0.
- R2: All samples and pilots are 15-bit two's complement values with 6 fraction bits, real and imaginary parts separate. Sample m of a column sits at bits [m*15 +: 15] of the column buses, and pilot j sits at bits [j*15 +: 15] of the pilot buses. The products are plain complex products, with no conjugation.
- R3: Output row m is computed in three steps. The exact sum S over j of Y[m][j]·p[j] is multiplied by the unsigned 16-bit scale, which has 14 fraction bits. The product has 2^19 added and is then shifted arithmetically right by 20 bits. Real and imaginary parts are treated separately.
- R4: A shifted result above 16383 is output as 16383, and one below -16384 is output as -16384.
- R5: A burst is SYMS consecutive cycles with col_valid high. The column accepted in the k-th of those cycles is multiplied by pilot k.
- R6: Suppose column 0 is accepted at clock edge E. Then row m is presented with out_valid high after edge E+SYMS+1+m, so the ROWS rows occupy consecutive cycles.
- R7: out_idx is 0 on the first valid row of a burst and rises by one on each following valid row, up to ROWS-1.
- R8: A col_valid that would start a new burst is ignored while the first element's buffer still holds rows of the previous burst, that is, within ROWS cycles of that burst's column 0.
- R9: A pilot and scale load made while the array is idle is used by the next burst.
- R10: A load requested during a burst does not alter that burst's results. It is applied once the array empties and is used by the following burst without another request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_valid | input | 1 | A received column is present |
| col_re | input | ROWS*DW | Real parts of the column, sample m at [m*DW +: DW] |
| col_im | input | ROWS*DW | Imaginary parts of the column |
| pil_load | input | 1 | Request to load pilots and scale |
| pil_re_in | input | SYMS*DW | Real parts of the pilots, pilot j at [j*DW +: DW] |
| pil_im_in | input | SYMS*DW | Imaginary parts of the pilots |
| scale_in | input | SCW | Unsigned scale, SFR fraction bits |
| out_valid | output | 1 | An estimate is present |
| out_idx | output | IW | Antenna index of the estimate |
| out_re | output | DW | Real part of the estimate |
| out_im | output | DW | Imaginary part of the estimate |

## Verification
The hardest situations to reach are the collisions in time. One is a load request that lands in the middle of a burst. The other is a stray column that arrives while the first element is still draining. Both can only be produced by placing a single-cycle pulse at an exact offset inside the burst sequence. The bench steps through each burst one clock at a time and can inject a pilot load or a stray column at any chosen step. It then checks that the current burst's results are untouched, and for the deferred load it checks that the following burst picks up the new pilot set.

// File: rtl/lsce_pkg.sv
package lsce_pkg;
   localparam int LSCE_DW   = 15;
   localparam int LSCE_FRAC = 6;
   localparam int LSCE_SCW  = 16;
   localparam int LSCE_SFR  = 14;

   function automatic int lsce_acc_w(input int dw, input int syms);
      return 2 * dw + 1 + ((syms > 1) ? $clog2(syms) : 1);
   endfunction
endpackage

// File: rtl/lsce_pe.sv
module lsce_pe #(
   parameter int ROWS = 8,
   parameter int DW   = 15,
   parameter int AW   = 33
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [ROWS*DW-1:0]   col_re,
   input  logic [ROWS*DW-1:0]   col_im,
   input  logic signed [DW-1:0] pil_re,
   input  logic signed [DW-1:0] pil_im,
   input  logic signed [AW-1:0] psin_re,
   input  logic signed [AW-1:0] psin_im,
   output logic signed [AW-1:0] psout_re,
   output logic signed [AW-1:0] psout_im,
   output logic                 psout_v,
   output logic                 empty
);
   localparam int CW = $clog2(ROWS + 1);

   logic signed [DW-1:0]   row_re [ROWS];
   logic signed [DW-1:0]   row_im [ROWS];
   logic [CW-1:0]          cnt;
   logic signed [2*DW-1:0] rr, ii, ri, ir;
   logic signed [AW-1:0]   prod_re, prod_im;

   assign empty = (cnt == '0);

   always_ff @(posedge clk) begin
      if (load) begin
         for (int i = 0; i < ROWS; i++) begin
            row_re[i] <= col_re[i*DW +: DW];
            row_im[i] <= col_im[i*DW +: DW];
         end
      end else if (!empty) begin
         for (int i = 0; i < ROWS - 1; i++) begin
            row_re[i] <= row_re[i+1];
            row_im[i] <= row_im[i+1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= CW'(ROWS);
      end else if (!empty) begin
         cnt <= cnt - 1'b1;
      end
   end

   always_comb begin
      rr = (2*DW)'(row_re[0]) * (2*DW)'(pil_re);
      ii = (2*DW)'(row_im[0]) * (2*DW)'(pil_im);
      ri = (2*DW)'(row_re[0]) * (2*DW)'(pil_im);
      ir = (2*DW)'(row_im[0]) * (2*DW)'(pil_re);
      prod_re = AW'(rr) - AW'(ii);
      prod_im = AW'(ri) + AW'(ir);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         psout_v <= 1'b0;
      end else begin
         psout_v <= !empty;
      end
   end

   always_ff @(posedge clk) begin
      psout_re <= psin_re + prod_re;
      psout_im <= psin_im + prod_im;
   end
endmodule

// File: rtl/lsce_scale.sv
module lsce_scale #(
   parameter int DW   = 15,
   parameter int AW   = 33,
   parameter int SCW  = 16,
   parameter int SFR  = 14,
   parameter int FRAC = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_v,
   input  logic signed [AW-1:0] in_re,
   input  logic signed [AW-1:0] in_im,
   input  logic [SCW-1:0]       scale,
   output logic                 out_v,
   output logic [DW-1:0]        out_re,
   output logic [DW-1:0]        out_im
);
   localparam int PW = AW + SCW + 1;
   localparam int SH = FRAC + SFR;
   localparam logic signed [PW-1:0] HALF = {{(PW-1){1'b0}}, 1'b1} << (SH - 1);
   localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [PW-1:0] MINV = ~MAXV;

   logic signed [PW-1:0] sc;
   logic signed [PW-1:0] p_re, p_im, s_re, s_im;
   logic [DW-1:0]        q_re, q_im;

   always_comb begin
      sc   = PW'($signed({1'b0, scale}));
      p_re = PW'(in_re) * sc;
      p_im = PW'(in_im) * sc;
      s_re = (p_re + HALF) >>> SH;
      s_im = (p_im + HALF) >>> SH;
      if (s_re > MAXV)      q_re = MAXV[DW-1:0];
      else if (s_re < MINV) q_re = MINV[DW-1:0];
      else                  q_re = s_re[DW-1:0];
      if (s_im > MAXV)      q_im = MAXV[DW-1:0];
      else if (s_im < MINV) q_im = MINV[DW-1:0];
      else                  q_im = s_im[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_v <= 1'b0;
      else        out_v <= in_v;
   end

   always_ff @(posedge clk) begin
      out_re <= q_re;
      out_im <= q_im;
   end
endmodule

// File: rtl/lsce_ctrl.sv
module lsce_ctrl #(
   parameter int SYMS = 4,
   parameter int DW   = 15,
   parameter int SCW  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               col_valid,
   input  logic               pe0_empty,
   input  logic               pipe_active,
   input  logic               pil_load,
   input  logic [SYMS*DW-1:0] pil_re_in,
   input  logic [SYMS*DW-1:0] pil_im_in,
   input  logic [SCW-1:0]     scale_in,
   output logic [SYMS-1:0]    load_vec,
   output logic [SYMS*DW-1:0] pil_re,
   output logic [SYMS*DW-1:0] pil_im,
   output logic [SCW-1:0]     scale,
   output logic               busy
);
   localparam int CIW = (SYMS > 1) ? $clog2(SYMS) : 1;

   logic [CIW-1:0]     col_idx;
   logic               take;
   logic               pend_v;
   logic [SYMS*DW-1:0] pend_re, pend_im;
   logic [SCW-1:0]     pend_sc;
   logic               apply;

   assign take  = col_valid && ((col_idx != '0) || pe0_empty);
   assign busy  = (col_idx != '0) || pipe_active;
   assign apply = pend_v && !busy;

   for (genvar j = 0; j < SYMS; j++) begin : g_ld
      assign load_vec[j] = take && (col_idx == CIW'(j));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_idx <= '0;
      end else if (take) begin
         col_idx <= (col_idx == CIW'(SYMS - 1)) ? '0 : col_idx + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v  <= 1'b0;
         pend_re <= '0;
         pend_im <= '0;
         pend_sc <= '0;
         pil_re  <= '0;
         pil_im  <= '0;
         scale   <= '0;
      end else begin
         if (apply) begin
            pil_re <= pend_re;
            pil_im <= pend_im;
            scale  <= pend_sc;
            pend_v <= 1'b0;
         end
         if (pil_load) begin
            pend_re <= pil_re_in;
            pend_im <= pil_im_in;
            pend_sc <= scale_in;
            pend_v  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/ls_chan_est.sv
module ls_chan_est
   import lsce_pkg::*;
#(
   parameter int ROWS = 8,
   parameter int SYMS = 4,
   parameter int DW   = LSCE_DW,
   parameter int FRAC = LSCE_FRAC,
   parameter int SCW  = LSCE_SCW,
   parameter int SFR  = LSCE_SFR,
   parameter int IW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               col_valid,
   input  logic [ROWS*DW-1:0] col_re,
   input  logic [ROWS*DW-1:0] col_im,
   input  logic               pil_load,
   input  logic [SYMS*DW-1:0] pil_re_in,
   input  logic [SYMS*DW-1:0] pil_im_in,
   input  logic [SCW-1:0]     scale_in,
   output logic               out_valid,
   output logic [IW-1:0]      out_idx,
   output logic [DW-1:0]      out_re,
   output logic [DW-1:0]      out_im
);
   localparam int AW = lsce_acc_w(DW, SYMS);

   if (SYMS < 2) begin : g_bad_syms
      $error("SYMS must be at least 2");
   end
   if (ROWS < 2) begin : g_bad_rows
      $error("ROWS must be at least 2");
   end
   if (FRAC >= DW) begin : g_bad_frac
      $error("FRAC must be below DW");
   end
   if (IW < $clog2(ROWS)) begin : g_bad_iw
      $error("IW too narrow for ROWS");
   end

   logic [SYMS-1:0]      load_vec;
   logic [SYMS*DW-1:0]   pil_cur_re, pil_cur_im;
   logic [SCW-1:0]       scale_cur;
   logic                 busy;
   logic [SYMS-1:0]      pe_empty, pe_v;
   logic signed [AW-1:0] ps_re [SYMS];
   logic signed [AW-1:0] ps_im [SYMS];
   logic [IW-1:0]        row_cnt;

   lsce_ctrl #(.SYMS(SYMS), .DW(DW), .SCW(SCW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .col_valid(col_valid),
      .pe0_empty(pe_empty[0]), .pipe_active((~&pe_empty) || (|pe_v)),
      .pil_load(pil_load), .pil_re_in(pil_re_in), .pil_im_in(pil_im_in),
      .scale_in(scale_in), .load_vec(load_vec), .pil_re(pil_cur_re),
      .pil_im(pil_cur_im), .scale(scale_cur), .busy(busy)
   );

   for (genvar j = 0; j < SYMS; j++) begin : g_pe
      logic signed [AW-1:0] in_re, in_im;
      if (j == 0) begin : g_head
         assign in_re = '0;
         assign in_im = '0;
      end else begin : g_link
         assign in_re = ps_re[j-1];
         assign in_im = ps_im[j-1];
      end
      lsce_pe #(.ROWS(ROWS), .DW(DW), .AW(AW)) u_pe (
         .clk(clk), .rst_n(rst_n), .load(load_vec[j]),
         .col_re(col_re), .col_im(col_im),
         .pil_re(pil_cur_re[j*DW +: DW]), .pil_im(pil_cur_im[j*DW +: DW]),
         .psin_re(in_re), .psin_im(in_im),
         .psout_re(ps_re[j]), .psout_im(ps_im[j]),
         .psout_v(pe_v[j]), .empty(pe_empty[j])
      );
   end

   lsce_scale #(.DW(DW), .AW(AW), .SCW(SCW), .SFR(SFR), .FRAC(FRAC)) u_scale (
      .clk(clk), .rst_n(rst_n), .in_v(pe_v[SYMS-1]),
      .in_re(ps_re[SYMS-1]), .in_im(ps_im[SYMS-1]), .scale(scale_cur),
      .out_v(out_valid), .out_re(out_re), .out_im(out_im)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_cnt <= '0;
         out_idx <= '0;
      end else if (pe_v[SYMS-1]) begin
         out_idx <= row_cnt;
         row_cnt <= (row_cnt == IW'(ROWS - 1)) ? '0 : row_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/ls_chan_est_chk.sv
module ls_chan_est_chk #(
   parameter int ROWS = 8,
   parameter int IW   = 3,
   parameter int PBW  = 60,
   parameter int SCW  = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           out_valid,
   input logic [IW-1:0]  out_idx,
   input logic           busy,
   input logic [PBW-1:0] pil_cur_re,
   input logic [PBW-1:0] pil_cur_im,
   input logic [SCW-1:0] scale_cur
);
   a_r7_first_row: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> out_idx == '0);

   a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |->
         out_idx == (($past(out_idx) == IW'(ROWS - 1)) ? '0 : $past(out_idx) + 1'b1));

   a_r10_pilot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> ($stable(pil_cur_re) && $stable(pil_cur_im)));

   a_r10_scale_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> $stable(scale_cur));
endmodule

bind ls_chan_est ls_chan_est_chk #(
   .ROWS(ROWS), .IW(IW), .PBW(SYMS*DW), .SCW(SCW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_idx(out_idx),
   .busy(busy), .pil_cur_re(pil_cur_re), .pil_cur_im(pil_cur_im),
   .scale_cur(scale_cur)
);

// File: tb/ls_chan_est_test.sv
`timescale 1ns/1ps
module ls_chan_est_test;
   localparam int ROWS = 8;
   localparam int SYMS = 4;
   localparam int DW   = 15;
   localparam int SCW  = 16;
   localparam int IW   = 3;
   localparam int NENT = 5;
   // fields: sample amplitude, pattern seed, pilot amplitude, scale
   localparam int TBL [NENT][4] = '{
      '{3000,  7,   100,  4096},
      '{500,   13,  300,  16384},
      '{12000, 5,   64,   2000},
      '{16383, 29,  16383, 65535},
      '{1,     3,   1,    1}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               col_valid = 1'b0;
   logic [ROWS*DW-1:0] col_re = '0, col_im = '0;
   logic               pil_load = 1'b0;
   logic [SYMS*DW-1:0] pil_re_in = '0, pil_im_in = '0;
   logic [SCW-1:0]     scale_in = '0;
   logic               out_valid;
   logic [IW-1:0]      out_idx;
   logic [DW-1:0]      out_re, out_im;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int yre [ROWS][SYMS];
   int yim [ROWS][SYMS];
   int pr [SYMS], pi [SYMS], sc;
   int nr [SYMS], ni [SYMS], nsc;

   ls_chan_est #(.ROWS(ROWS), .SYMS(SYMS)) uut (
      .clk(clk), .rst_n(rst_n), .col_valid(col_valid), .col_re(col_re),
      .col_im(col_im), .pil_load(pil_load), .pil_re_in(pil_re_in),
      .pil_im_in(pil_im_in), .scale_in(scale_in), .out_valid(out_valid),
      .out_idx(out_idx), .out_re(out_re), .out_im(out_im)
   );

   always #10 clk = ~clk;

   function automatic int fix(input longint s, input int scl);
      longint r;
      r = (s * scl + 64'sd524288) >>> 20;
      if (r > 16383) r = 16383;
      if (r < -16384) r = -16384;
      return int'(r);
   endfunction

   function automatic int sx(input logic [DW-1:0] v);
      return int'($signed(v));
   endfunction

   task automatic fill_entry(input int e);
      int ya, a, pa;
      ya = TBL[e][0]; a = TBL[e][1]; pa = TBL[e][2];
      for (int m = 0; m < ROWS; m++)
         for (int j = 0; j < SYMS; j++) begin
            yre[m][j] = ((a*(m+1)*(j+3) + 37*m + 11*j) % (2*ya+1)) - ya;
            yim[m][j] = ((a*(m+2)*(j+1) + 19*j + 5*m) % (2*ya+1)) - ya;
         end
      for (int j = 0; j < SYMS; j++) begin
         nr[j] = ((a*5*(j+1) + 3*j*j + 1) % (2*pa+1)) - pa;
         ni[j] = ((a*3*(j+2) + 7*j) % (2*pa+1)) - pa;
      end
      nsc = TBL[e][3];
   endtask

   task automatic drive_pilots();
      for (int j = 0; j < SYMS; j++) begin
         pil_re_in[j*DW +: DW] = nr[j][DW-1:0];
         pil_im_in[j*DW +: DW] = ni[j][DW-1:0];
      end
      scale_in = nsc[SCW-1:0];
   endtask

   task automatic adopt_next();
      for (int j = 0; j < SYMS; j++) begin pr[j] = nr[j]; pi[j] = ni[j]; end
      sc = nsc;
   endtask

   task automatic load_idle();
      @(negedge clk);
      drive_pilots();
      pil_load = 1'b1;
      @(negedge clk);
      pil_load = 1'b0;
      repeat (3) @(negedge clk);
      adopt_next();
   endtask

   task automatic put_col(input int j);
      for (int m = 0; m < ROWS; m++) begin
         col_re[m*DW +: DW] = yre[m][j][DW-1:0];
         col_im[m*DW +: DW] = yim[m][j][DW-1:0];
      end
   endtask

   // stray_k / midload_k: step at which to inject a stray column / a load (-1 none)
   task automatic run_burst(input string req, input int stray_k, input int midload_k);
      int er, ei;
      longint sr, si;
      @(negedge clk);
      put_col(0);
      col_valid = 1'b1;
      for (int k = 0; k <= SYMS + ROWS + 1; k++) begin
         @(negedge clk);
         if (k + 1 < SYMS) begin
            put_col(k + 1);
            col_valid = 1'b1;
         end else if (k == stray_k) begin
            col_re = {ROWS{15'sd5000}};
            col_im = {ROWS{15'sd4000}};
            col_valid = 1'b1;
         end else begin
            col_valid = 1'b0;
         end
         if (k == midload_k) begin
            drive_pilots();
            pil_load = 1'b1;
         end else begin
            pil_load = 1'b0;
         end
         if (k == SYMS) begin
            checks++;
            if (out_valid !== 1'b0) begin
               errors++;
               $display("FAIL %s early row: out_valid=%b expected 0", req, out_valid);
            end
         end
         if (k >= SYMS + 1 && k <= SYMS + ROWS) begin
            int m;
            m = k - SYMS - 1;
            sr = 0; si = 0;
            for (int j = 0; j < SYMS; j++) begin
               sr += longint'(yre[m][j]) * pr[j] - longint'(yim[m][j]) * pi[j];
               si += longint'(yre[m][j]) * pi[j] + longint'(yim[m][j]) * pr[j];
            end
            er = fix(sr, sc);
            ei = fix(si, sc);
            checks++;
            if (out_valid !== 1'b1 || out_idx != IW'(m) || sx(out_re) != er || sx(out_im) != ei) begin
               errors++;
               $display("FAIL %s row %0d: valid=%b idx=%0d re=%0d im=%0d expected valid=1 idx=%0d re=%0d im=%0d",
                        req, m, out_valid, out_idx, sx(out_re), sx(out_im), m, er, ei);
            end
         end
      end
      col_valid = 1'b0;
      pil_load = 1'b0;
      repeat (ROWS + 3) @(negedge clk);
   endtask

   initial begin
      for (int j = 0; j < SYMS; j++) begin pr[j] = 0; pi[j] = 0; end
      sc = 0;
      // R1: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 in reset: out_valid=%b expected 0", out_valid);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 after reset: out_valid=%b expected 0", out_valid);
      end

      // table walk: R2 R3 R4 R5 R6 R7 R9
      for (int e = 0; e < NENT; e++) begin
         fill_entry(e);
         load_idle();
         run_burst("R2 R3 R4 R5 R6 R7 R9", -1, -1);
      end

      // R4: forced saturation in both directions
      for (int m = 0; m < ROWS; m++)
         for (int j = 0; j < SYMS; j++) begin
            yre[m][j] = (m % 2 == 0) ? 16383 : -16384;
            yim[m][j] = 0;
         end
      for (int j = 0; j < SYMS; j++) begin nr[j] = 16383; ni[j] = 100; end
      nsc = 65535;
      load_idle();
      run_burst("R4", -1, -1);

      // R10: load requested mid-burst is deferred
      fill_entry(0);
      load_idle();
      fill_entry(1);
      for (int m = 0; m < ROWS; m++)
         for (int j = 0; j < SYMS; j++) begin
            yre[m][j] = ((7*(m+1)*(j+3) + 37*m + 11*j) % 6001) - 3000;
            yim[m][j] = ((7*(m+2)*(j+1) + 19*j + 5*m) % 6001) - 3000;
         end
      run_burst("R10 held", -1, 1);
      adopt_next();
      run_burst("R10 applied", -1, -1);

      // R8: stray column while first element drains
      fill_entry(2);
      load_idle();
      run_burst("R8 stray", SYMS, -1);
      run_burst("R8 after", -1, -1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #3_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule